// File: doc/BRIEF.md
# Memory Bus Cycle Sequencer

This block carries one processor-side memory access across a 16-bit external bus, one bus clock per phase: T1, T2, T3, then optional wait phases Tw, then T4. It generates the active-low read and write strobes and three staggered DRAM timing references. The row-strobe reference falls first, the address-multiplexer reference falls next, and the column-strobe reference falls last. All three rise together when T4 ends.

A request is taken from a simple parallel interface while the sequencer is idle. It is a read, a write or a refresh, and it is either a word or a single byte. The addressed memory reports its width at the end of T3. If a word access lands on byte-wide memory, the sequencer runs a second transfer to the odd byte on its own. The two bytes are gathered from the upper data lane. The access ends with a one-cycle done pulse, and on reads the result appears on `rdata`.

The raw reset input is filtered. Only a low level held for at least `RST_MIN` clocks takes effect, and shorter pulses pass without effect.

Top module: `mbus_seq`

## Requirements
- R1: A request seen with `req_valid` high while idle starts T1 in the next clock. T1, T2, T3 and T4 each last exactly one clock, and `busy` is high from T1 through T4.
- R2: On read transfers `mrd_n` is low from T2 through T4, including any Tw. It is high at all other times and on every other kind of transfer.
- R3: On write transfers `mwr_n` is low from T3 through T4, including any Tw. It is high otherwise, and `mrd_n` and `mwr_n` are never low together.
- R4: `tref_r_n` is low from T2 to T4. `tref_a_n` is low from T3 to T4. `tref_c_n` is low in Tw and T4. All three are high in T1 and while idle.
- R5: `wait_n` is sampled at the end of T3 and at the end of each Tw. While it is sampled low, one more Tw is inserted, and every strobe keeps its level during Tw.
- R6: `msize_n` is sampled at the end of T3 of the first transfer, where low means byte-wide memory. A word access then runs a second full T1–T4 transfer right after T4. In that transfer `bus_addr` bit 0 is 1, `bhen_n` is 1 and `blen_n` is 0. The read result is {first D15–D8, second D15–D8}.
- R7: A word access drives `bus_addr` with bit 0 cleared and both enables low in its first transfer. On word-wide memory it returns D15–D0. A byte access keeps the address as given and drives `bhen_n` low for an even address or `blen_n` low for an odd address. It returns its byte in `rdata[7:0]` with the upper byte zero. The byte comes from D15–D8 if the address is even or the memory is byte-wide, and from D7–D0 otherwise.
- R8: On refresh transfers `mrd_n`, `mwr_n`, `bhen_n` and `blen_n` stay high, the three references run their normal sequence, and no second transfer is ever made.
- R9: `rst_n_raw` held low for `RST_MIN` (5) consecutive clocks aborts any transfer and returns all outputs to idle. A low pulse of fewer clocks has no effect.
- R10: `done` is high for exactly the one clock after T4 of the final transfer. On reads, `rdata` holds the assembled data from that clock on.
- R11: `bus_oe` is high from T1 to T4 of writes only. `bus_dout` carries the full write word in the first transfer of a word write; in every other write transfer it carries the low write byte on both lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n_raw | input | 1 | Unfiltered active-low reset |
| req_valid | input | 1 | Request present (taken when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_refresh | input | 1 | 1 = refresh transfer (overrides req_write) |
| req_word | input | 1 | 1 = 16-bit access, 0 = single byte |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write data |
| wait_n | input | 1 | Active-low wait request |
| msize_n | input | 1 | Low = addressed memory is byte-wide |
| bus_din | input | DW | Read data from the bus |
| bus_addr | output | AW | Transfer address |
| bus_dout | output | DW | Write data to the bus |
| bus_oe | output | 1 | Write data drive enable |
| bhen_n | output | 1 | Upper lane (D15–D8, even byte) enable, active low |
| blen_n | output | 1 | Lower lane (D7–D0, odd byte) enable, active low |
| mrd_n | output | 1 | Memory read strobe |
| mwr_n | output | 1 | Memory write strobe |
| tref_r_n | output | 1 | Row-strobe timing reference |
| tref_a_n | output | 1 | Address-mux timing reference |
| tref_c_n | output | 1 | Column-strobe timing reference |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | DW | Assembled read data |

## Verification
The bench targets the following corner cases and the faults each one would expose:
- A word read or write on byte-wide memory. A design that skipped the second transfer, reused the even address or kept the upper enable low would return or write the wrong byte.
- Long wait runs and the zero-wait case. An off-by-one in wait sampling would move T4 by a clock, and a strobe that changed during Tw would break the per-cycle level check.
- Refresh transfers with `msize_n` low. These catch a read strobe that leaks out or a refresh that is wrongly split.
- A four-clock reset pulse in the middle of a transfer, which must leave it untouched, and a longer pulse, which must abort it with no done pulse.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bstate_e;

  typedef enum logic [1:0] {
    K_READ    = 2'd0,
    K_WRITE   = 2'd1,
    K_REFRESH = 2'd2
  } xkind_e;

  typedef struct packed {
    logic rd_n;
    logic wr_n;
    logic r_n;
    logic a_n;
    logic c_n;
  } strb_t;

  // Strobe levels as a function of the current phase and transfer kind.
  function automatic strb_t strobe_levels(bstate_e st, xkind_e k);
    strb_t s;
    logic past_t1;
    logic past_t2;
    logic past_t3;
    past_t1 = (st == ST_T2) || (st == ST_T3) || (st == ST_TW) || (st == ST_T4);
    past_t2 = (st == ST_T3) || (st == ST_TW) || (st == ST_T4);
    past_t3 = (st == ST_TW) || (st == ST_T4);
    s.r_n  = !past_t1;
    s.a_n  = !past_t2;
    s.c_n  = !past_t3;
    s.rd_n = !(past_t1 && (k == K_READ));
    s.wr_n = !(past_t2 && (k == K_WRITE));
    return s;
  endfunction

  // Lane enables {upper, lower}, active low, for an active transfer.
  function automatic logic [1:0] lane_enables_n(xkind_e k, logic word, logic a0, logic second);
    logic [1:0] en;
    if (k == K_REFRESH)  en = 2'b11;
    else if (word)       en = second ? 2'b10 : 2'b00;
    else                 en = a0 ? 2'b10 : 2'b01;
    return en;
  endfunction

  // Request bits to transfer kind; refresh takes priority.
  function automatic xkind_e decode_kind(logic wr, logic rf);
    xkind_e k;
    if (rf)      k = K_REFRESH;
    else if (wr) k = K_WRITE;
    else         k = K_READ;
    return k;
  endfunction

endpackage

// File: rtl/mbus_rst_filt.sv
module mbus_rst_filt #(
  parameter int RST_MIN = 5
) (
  input  logic clk,
  input  logic rst_n_raw,
  output logic rst_act
);
  localparam int CW = $clog2(RST_MIN + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_MIN - 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst_n_raw) begin
      low_cnt <= '0;
      rst_act <= 1'b0;
    end else if (low_cnt == LAST) begin
      rst_act <= 1'b1;
    end else begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  // R9: a high raw input always releases the internal reset on the next edge
  a_r9_release: assert property (@(posedge clk) rst_n_raw |=> !rst_act);

endmodule

// File: rtl/mbus_ctl.sv
module mbus_ctl
  import mbus_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_refresh,
  input  logic          req_word,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          wait_n,
  input  logic          msize_n,
  output bstate_e       st,
  output xkind_e        kind_q,
  output logic          word_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          second_q,
  output logic          bytemem_q,
  output logic          done
);

  logic accept;
  logic ev_t3_end;
  logic ev_split;
  logic ev_last;
  logic stall;

  assign accept    = (st == ST_IDLE) && req_valid;
  assign ev_t3_end = (st == ST_T3);
  assign stall     = ((st == ST_T3) || (st == ST_TW)) && !wait_n;
  assign ev_split  = (st == ST_T4) && !second_q && bytemem_q && word_q;
  assign ev_last   = (st == ST_T4) && !ev_split;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      kind_q    <= K_READ;
      word_q    <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      second_q  <= 1'b0;
      bytemem_q <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= ev_last;
      if (accept) begin
        kind_q    <= decode_kind(req_write, req_refresh);
        word_q    <= req_word;
        addr_q    <= req_addr;
        wdata_q   <= req_wdata;
        second_q  <= 1'b0;
        bytemem_q <= 1'b0;
      end
      if (ev_t3_end && !second_q && (kind_q != K_REFRESH))
        bytemem_q <= !msize_n;
      if (ev_split)
        second_q <= 1'b1;
      case (st)
        ST_IDLE: if (accept) st <= ST_T1;
        ST_T1:   st <= ST_T2;
        ST_T2:   st <= ST_T3;
        ST_T3:   st <= stall ? ST_TW : ST_T4;
        ST_TW:   st <= stall ? ST_TW : ST_T4;
        ST_T4:   st <= ev_split ? ST_T1 : ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5: a low wait sample at the end of T3 or Tw yields a Tw
  a_r5_wait_stall: assert property (@(posedge clk) disable iff (rst)
    (((st == ST_T3) || (st == ST_TW)) && !wait_n) |=> (st == ST_TW));
  // R5: a high wait sample ends the wait run
  a_r5_wait_exit: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_TW) && wait_n) |=> (st == ST_T4));
  // R6: a split goes straight to T1 of the odd-byte transfer
  a_r6_split_restart: assert property (@(posedge clk) disable iff (rst)
    ev_split |=> ((st == ST_T1) && second_q));
  // R8: refresh never reaches a second transfer
  a_r8_refresh_single: assert property (@(posedge clk) disable iff (rst)
    ((kind_q == K_REFRESH) && (st != ST_IDLE)) |-> !second_q);
  // R10: done lasts one clock
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R1: a transfer is never entered from T4 into T2
  a_r1_t1_first: assert property (@(posedge clk) disable iff (rst)
    (st == ST_T1) |=> (st == ST_T2));

endmodule

// File: rtl/mbus_strobe.sv
module mbus_strobe
  import mbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  bstate_e st,
  input  xkind_e  kind_q,
  output logic    mrd_n,
  output logic    mwr_n,
  output logic    tref_r_n,
  output logic    tref_a_n,
  output logic    tref_c_n
);

  strb_t lv;

  always_comb lv = strobe_levels(st, kind_q);

  assign mrd_n    = lv.rd_n;
  assign mwr_n    = lv.wr_n;
  assign tref_r_n = lv.r_n;
  assign tref_a_n = lv.a_n;
  assign tref_c_n = lv.c_n;

  // R3: read and write strobes are never active together
  a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!mrd_n && !mwr_n));
  // R4: the mux reference falls only after the row reference is already low
  a_r4_a_after_r: assert property (@(posedge clk) disable iff (rst)
    $fell(tref_a_n) |-> (!tref_r_n && !$past(tref_r_n)));
  // R4: the column reference falls only after the mux reference is already low
  a_r4_c_after_a: assert property (@(posedge clk) disable iff (rst)
    $fell(tref_c_n) |-> (!tref_a_n && !$past(tref_a_n)));
  // R4: all references return high together
  a_r4_rise_together: assert property (@(posedge clk) disable iff (rst)
    $rose(tref_r_n) |-> (tref_a_n && tref_c_n));
  // R2: the read strobe is never active outside the row window
  a_r2_rd_in_window: assert property (@(posedge clk) disable iff (rst)
    !mrd_n |-> !tref_r_n);

endmodule

// File: rtl/mbus_dpath.sv
module mbus_dpath
  import mbus_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  bstate_e       st,
  input  xkind_e        kind_q,
  input  logic          word_q,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] wdata_q,
  input  logic          second_q,
  input  logic          bytemem_q,
  input  logic [DW-1:0] bus_din,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  output logic          bhen_n,
  output logic          blen_n,
  output logic [DW-1:0] rdata
);
  localparam int LW = DW / 2;

  logic          active;
  logic          capture;
  logic [LW-1:0] din_hi;
  logic [LW-1:0] din_lo;
  logic [LW-1:0] byte_pick;

  assign active  = (st != ST_IDLE);
  assign capture = (st == ST_T4) && (kind_q == K_READ);
  assign din_hi  = bus_din[DW-1:LW];
  assign din_lo  = bus_din[LW-1:0];
  assign byte_pick = (bytemem_q || !addr_q[0]) ? din_hi : din_lo;

  assign bus_addr = {addr_q[AW-1:1], word_q ? second_q : addr_q[0]};
  assign bus_oe   = active && (kind_q == K_WRITE);
  assign bus_dout = (word_q && !second_q) ? wdata_q : {wdata_q[LW-1:0], wdata_q[LW-1:0]};
  assign {bhen_n, blen_n} = active ? lane_enables_n(kind_q, word_q, addr_q[0], second_q) : 2'b11;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (capture) begin
      if (!word_q)         rdata <= {{LW{1'b0}}, byte_pick};
      else if (!bytemem_q) rdata <= bus_din;
      else if (!second_q)  rdata[DW-1:LW] <= din_hi;
      else                 rdata[LW-1:0]  <= din_hi;
    end
  end

  // R6: the second transfer targets the odd byte on the lower enable only
  a_r6_odd_second: assert property (@(posedge clk) disable iff (rst)
    (second_q && active) |-> (bus_addr[0] && bhen_n && !blen_n));
  // R8: refresh drives no lane enable
  a_r8_refresh_lanes: assert property (@(posedge clk) disable iff (rst)
    (active && (kind_q == K_REFRESH)) |-> (bhen_n && blen_n && !bus_oe));
  // R11: write data is only driven while a write is running
  a_r11_oe_idle: assert property (@(posedge clk) disable iff (rst)
    !active |-> !bus_oe);

endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
  import mbus_pkg::*;
#(
  parameter int AW      = 24,
  parameter int DW      = 16,
  parameter int RST_MIN = 5
) (
  input  logic          clk,
  input  logic          rst_n_raw,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_refresh,
  input  logic          req_word,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          wait_n,
  input  logic          msize_n,
  input  logic [DW-1:0] bus_din,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe,
  output logic          bhen_n,
  output logic          blen_n,
  output logic          mrd_n,
  output logic          mwr_n,
  output logic          tref_r_n,
  output logic          tref_a_n,
  output logic          tref_c_n,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata
);

  logic          rst_act;
  bstate_e       st;
  xkind_e        kind_q;
  logic          word_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          second_q;
  logic          bytemem_q;

  mbus_rst_filt #(.RST_MIN(RST_MIN)) u_filt (
    .clk       (clk),
    .rst_n_raw (rst_n_raw),
    .rst_act   (rst_act)
  );

  mbus_ctl #(.AW(AW), .DW(DW)) u_ctl (
    .clk         (clk),
    .rst         (rst_act),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_refresh (req_refresh),
    .req_word    (req_word),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .wait_n      (wait_n),
    .msize_n     (msize_n),
    .st          (st),
    .kind_q      (kind_q),
    .word_q      (word_q),
    .addr_q      (addr_q),
    .wdata_q     (wdata_q),
    .second_q    (second_q),
    .bytemem_q   (bytemem_q),
    .done        (done)
  );

  mbus_strobe u_strb (
    .clk      (clk),
    .rst      (rst_act),
    .st       (st),
    .kind_q   (kind_q),
    .mrd_n    (mrd_n),
    .mwr_n    (mwr_n),
    .tref_r_n (tref_r_n),
    .tref_a_n (tref_a_n),
    .tref_c_n (tref_c_n)
  );

  mbus_dpath #(.AW(AW), .DW(DW)) u_dp (
    .clk       (clk),
    .rst       (rst_act),
    .st        (st),
    .kind_q    (kind_q),
    .word_q    (word_q),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .second_q  (second_q),
    .bytemem_q (bytemem_q),
    .bus_din   (bus_din),
    .bus_addr  (bus_addr),
    .bus_dout  (bus_dout),
    .bus_oe    (bus_oe),
    .bhen_n    (bhen_n),
    .blen_n    (blen_n),
    .rdata     (rdata)
  );

  assign busy = (st != ST_IDLE);

  // R1: busy and the row reference agree once past T1
  a_r1_busy_cover: assert property (@(posedge clk) disable iff (rst_act)
    !tref_r_n |-> busy);

endmodule

// File: tb/sim_mbus_seq.sv
`timescale 1ns/1ps
module sim_mbus_seq;
  localparam int AW = 24;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n_raw = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_refresh = 1'b0, req_word = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          wait_n = 1'b1, msize_n = 1'b1;
  logic [DW-1:0] bus_din = '0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout, rdata;
  logic          bus_oe, bhen_n, blen_n, mrd_n, mwr_n, tref_r_n, tref_a_n, tref_c_n, busy, done;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  mbus_seq #(.AW(AW), .DW(DW), .RST_MIN(5)) u0 (
    .clk(clk), .rst_n_raw(rst_n_raw), .req_valid(req_valid), .req_write(req_write),
    .req_refresh(req_refresh), .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .wait_n(wait_n), .msize_n(msize_n), .bus_din(bus_din), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .bhen_n(bhen_n), .blen_n(blen_n), .mrd_n(mrd_n),
    .mwr_n(mwr_n), .tref_r_n(tref_r_n), .tref_a_n(tref_a_n), .tref_c_n(tref_c_n),
    .busy(busy), .done(done), .rdata(rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected {rd, wr, r, a, c} in cycle c of a transfer (1 = T1).
  function automatic logic [4:0] exp_strobes(bit wr, bit rf, int c);
    logic rd_lo, wr_lo;
    rd_lo = !rf && !wr && (c >= 2);
    wr_lo = !rf && wr && (c >= 3);
    return {!rd_lo, !wr_lo, !(c >= 2), !(c >= 3), !(c >= 4)};
  endfunction

  function automatic logic [1:0] exp_lanes(bit rf, bit wd, logic a0, int p);
    if (rf) return 2'b11;
    if (wd) return (p == 1) ? 2'b10 : 2'b00;
    return a0 ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [15:0] exp_read(bit wd, bit bmem, logic a0, logic [15:0] d0, logic [15:0] d1);
    if (wd) return bmem ? {d0[15:8], d1[15:8]} : d0;
    return {8'h00, (bmem || !a0) ? d0[15:8] : d0[7:0]};
  endfunction

  task automatic run_txn(input bit wr, input bit rf, input bit wd, input logic [AW-1:0] ad,
                         input logic [15:0] wdt, input int nw, input bit bmem, input bit srst);
    logic [15:0] t4d [2];
    int nph;
    logic [4:0] es;
    logic [AW-1:0] ea;
    t4d[0] = '0; t4d[1] = '0;
    @(negedge clk);
    req_write = wr; req_refresh = rf; req_word = wd; req_addr = ad; req_wdata = wdt; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    nph = (wd && !rf && bmem) ? 2 : 1;
    for (int p = 0; p < nph; p++) begin
      bit bad_s, bad_l, bad_d, bad_b;
      logic [4:0] as_;
      bad_s = 0; bad_l = 0; bad_d = 0; bad_b = 0; as_ = '0; es = '0;
      for (int c = 1; c <= 4 + nw; c++) begin
        es = exp_strobes(wr, rf, c);
        if ({mrd_n, mwr_n, tref_r_n, tref_a_n, tref_c_n} !== es) begin
          bad_s = 1; as_ = {mrd_n, mwr_n, tref_r_n, tref_a_n, tref_c_n};
        end
        ea = wd ? {ad[AW-1:1], (p == 1)} : ad;
        if ({bhen_n, blen_n} !== exp_lanes(rf, wd, ad[0], p) || bus_addr !== ea) bad_l = 1;
        if (bus_oe !== (wr && !rf)) bad_d = 1;
        if (wr && !rf && bus_dout !== ((wd && p == 0) ? wdt : {wdt[7:0], wdt[7:0]})) bad_d = 1;
        if (busy !== 1'b1) bad_b = 1;
        wait_n  = !((c >= 3) && (c < 3 + nw));
        msize_n = (c == 3) ? !bmem : 1'($urandom);
        bus_din = 16'($urandom);
        if (c == 4 + nw) t4d[p] = bus_din;
        if (srst && p == 0 && c == 2) rst_n_raw = 1'b0;
        if (srst && p == 0 && c == 6) rst_n_raw = 1'b1;
        @(negedge clk);
      end
      chk(!bad_s, "R2/R3/R4/R5 strobe sequence", {27'd0, as_}, {27'd0, es});
      chk(!bad_l, (p == 1) ? "R6 second transfer lanes" : "R7 address and lanes",
          {8'd0, bus_addr}, {8'd0, ea});
      chk(!bad_d, "R11 write data drive", {15'd0, bus_oe, bus_dout}, {15'd0, (wr && !rf), wdt});
      chk(!bad_b, "R1 busy through T1..T4", 32'(busy), 32'd1);
    end
    wait_n = 1'b1;
    chk(done === 1'b1 && busy === 1'b0, "R10 done after final T4", {30'd0, done, busy}, 32'b10);
    if (!wr && !rf)
      chk(rdata === exp_read(wd, bmem, ad[0], t4d[0], t4d[1]),
          wd && bmem ? "R6 split read assembly" : "R7 read data",
          {16'd0, rdata}, {16'd0, exp_read(wd, bmem, ad[0], t4d[0], t4d[1])});
    @(negedge clk);
    chk(done === 1'b0, "R10 done single clock", 32'(done), 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    bit saw_done;
    void'($urandom(32'd1234));
    repeat (6) @(negedge clk);
    rst_n_raw = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk({mrd_n, mwr_n, tref_r_n, tref_a_n, tref_c_n, bhen_n, blen_n} === 7'h7F && !busy && !done && !bus_oe,
        "R9 idle after reset", {25'd0, mrd_n, mwr_n, tref_r_n, tref_a_n, tref_c_n, bhen_n, blen_n}, 32'h7F);

    // Directed corner cases
    run_txn(0, 0, 1, 24'h001234, 16'h0, 0, 0, 0);   // R7 word read, no wait
    run_txn(0, 0, 1, 24'h000401, 16'h0, 2, 1, 0);   // R6 split read, odd request address forced even
    run_txn(1, 0, 1, 24'h000800, 16'hA55A, 1, 1, 0);// R6 split write
    run_txn(0, 0, 0, 24'h000003, 16'h0, 0, 0, 0);   // R7 odd byte on word memory
    run_txn(0, 0, 0, 24'h000005, 16'h0, 0, 1, 0);   // R7 odd byte on byte memory
    run_txn(1, 0, 0, 24'h000006, 16'h00C3, 0, 0, 0);// R11 byte write
    run_txn(0, 1, 1, 24'h000010, 16'h0, 1, 1, 0);   // R8 refresh ignores msize
    run_txn(0, 0, 1, 24'h000020, 16'h0, 6, 0, 0);   // R5 long wait
    run_txn(1, 0, 1, 24'h000030, 16'h1234, 2, 0, 1);// R9 short reset pulse ignored

    // R9 long reset aborts a stalled transfer
    @(negedge clk);
    req_write = 0; req_refresh = 0; req_word = 1; req_addr = 24'h40; req_valid = 1;
    @(negedge clk);
    req_valid = 0; wait_n = 1'b0; rst_n_raw = 1'b0;
    saw_done = 0;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (done) saw_done = 1;
    end
    chk(!busy && mrd_n && tref_r_n && tref_c_n && !saw_done, "R9 long reset aborts",
        {28'd0, busy, mrd_n, tref_r_n, saw_done}, 32'b0110);
    rst_n_raw = 1'b1; wait_n = 1'b1;
    @(negedge clk);
    @(negedge clk);

    // Constrained random
    for (int k = 0; k < 60; k++) begin
      bit rf_r, wr_r, wd_r, bm_r;
      int sel;
      sel  = int'($urandom % 5);
      rf_r = (sel == 0);
      wr_r = (sel == 1) || (sel == 2);
      wd_r = 1'($urandom);
      bm_r = 1'($urandom);
      run_txn(wr_r, rf_r, wd_r, AW'($urandom), 16'($urandom), int'($urandom % 4), bm_r, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule